// File: doc/BRIEF.md
# Prescaled Up-Counting Match Timer

This block is a bus-mapped timer for a system tick. A prescaler divides the bus clock by a programmed terminal value plus one. Each wrap of the prescaler advances a free-running up-counter by one. The counter is compared with a match register. When the comparison is enabled and the two are equal, a sticky status flag sets, and the interrupt line follows that flag. A match never reloads or stops the counter. To schedule the next event, software adds a period to the match register. If the handler ran late, it keeps adding periods until the match value is ahead of the counter again.

Software clears the counter with a control bit and waits until the counter reads zero. Writing zero to the control register stops counting. A debug-freeze control bit holds the counter while the external halt input is high.

The register map, at byte offsets:

| Offset | Register | Contents |
|---|---|---|
| 0x00 | control | bit0 run, bit1 clear-count, bit2 debug freeze |
| 0x04 | match enable | bit0 |
| 0x08 | prescale terminal | terminal value |
| 0x0C | counter | read-only |
| 0x10 | match 0 | match value |
| 0x14 | status | bit0, write-one-to-clear |

Reads return data on the cycle after the request.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, `irq` is low and the counter does not advance.
- R2: While running, the counter moves up by exactly one each time the prescaler wraps. The prescaler wraps once every (terminal+1) enabled clock cycles, so after E enabled cycles from a cleared state the counter holds floor(E/(terminal+1)).
- R3: The control run bit (bit0) starts counting. Writing the control register with bit0 at zero stops counting, and the counter keeps its value.
- R4: While control bit1 (clear-count) is set, the counter and the prescaler are held at zero, even if bit0 is set. Counting resumes from zero once bit1 is written back to zero.
- R5: With control bit2 set and `dbg_halt` high, the counter holds its value. With bit2 clear, `dbg_halt` has no effect on counting.
- R6: With the match enable bit (offset 0x04, bit0) set, status bit0 sets when the counter equals match 0. The counter keeps counting past the match.
- R7: Writing status with bit0 at one clears the flag. Writing it with bit0 at zero leaves the flag unchanged.
- R8: If a match and a clear of the flag happen in the same cycle, the flag stays set.
- R9: `irq` is high exactly when the status flag and the match enable bit are both set. Clearing the enable bit drops `irq` but keeps the flag.
- R10: The counter wraps from all-ones to zero and carries on counting, with no flag and no stop.
- R11: Reads of the match 0 and prescale registers return the written values. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| dbg_halt | input | 1 | External debug session active |
| irq | output | 1 | Match interrupt |

## Verification
The main collision is between a match setting the status flag and a software write-one-to-clear of that same flag. The bench provokes it by stopping the counter at a value equal to match 0. The comparison then stays true on every cycle, so any clear write lands together with a match. The flag must read back as one afterwards. The bench then moves match 0 away and clears again to show the clear itself works. A second overlap, clear-count while running, is judged by the counter reading zero and staying there.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int REG_W = 32;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MEN  = 8'h04;
  localparam logic [7:0] OFS_PSC  = 8'h08;
  localparam logic [7:0] OFS_CNT  = 8'h0C;
  localparam logic [7:0] OFS_MAT0 = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam int CTRL_RUN = 0;
  localparam int CTRL_CLR = 1;
  localparam int CTRL_DBG = 2;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [PSC_W-1:0] terminal,
  output logic             wrap
);
  logic [PSC_W-1:0] pre_q;

  assign wrap = run && (pre_q >= terminal);

  always_ff @(posedge clk) begin
    if (rst || clear)  pre_q <= '0;
    else if (wrap)     pre_q <= '0;
    else if (run)      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (step)    count <= count + 1'b1;
  end
endmodule

// File: rtl/mt_match.sv
module mt_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match_val,
  input  logic             w1c,
  output logic             flag,
  output logic             flag_next
);
  logic hit;
  assign hit       = enable && (count == match_val);
  assign flag_next = hit || (flag && !w1c);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_next;
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              dbg_halt,
  output logic              irq
);
  localparam int CPAD = REG_W - CNT_W;
  localparam int PPAD = REG_W - PSC_W;

  logic             ctrl_run, ctrl_clr, ctrl_dbg;
  logic             men;
  logic [PSC_W-1:0] psc_term;
  logic [CNT_W-1:0] mat0;
  logic [CNT_W-1:0] count;
  logic             flag, flag_next, wrap;
  logic             wr, rd, freeze, run, pre_clear, w1c, men_next;
  logic [7:0]       ofs;
  logic [REG_W-1:0] rd_mux;

  assign ofs       = 8'(bus_addr);
  assign wr        = bus_sel && bus_we;
  assign rd        = bus_sel && !bus_we;
  assign freeze    = ctrl_dbg && dbg_halt;
  assign pre_clear = ctrl_clr || !ctrl_run;
  assign run       = ctrl_run && !ctrl_clr && !freeze;
  assign w1c       = wr && (ofs == OFS_STAT) && bus_wdata[0];
  assign men_next  = (wr && ofs == OFS_MEN) ? bus_wdata[0] : men;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_run <= 1'b0;
      ctrl_clr <= 1'b0;
      ctrl_dbg <= 1'b0;
      men      <= 1'b0;
      psc_term <= '0;
      mat0     <= '0;
    end else if (wr) begin
      case (ofs)
        OFS_CTRL: begin
          ctrl_run <= bus_wdata[CTRL_RUN];
          ctrl_clr <= bus_wdata[CTRL_CLR];
          ctrl_dbg <= bus_wdata[CTRL_DBG];
        end
        OFS_MEN:  men      <= bus_wdata[0];
        OFS_PSC:  psc_term <= bus_wdata[PSC_W-1:0];
        OFS_MAT0: mat0     <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  mt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .clear(pre_clear), .run(run),
    .terminal(psc_term), .wrap(wrap)
  );

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(ctrl_clr), .step(wrap), .count(count)
  );

  mt_match #(.CNT_W(CNT_W)) u_mat (
    .clk(clk), .rst(rst), .enable(men), .count(count), .match_val(mat0),
    .w1c(w1c), .flag(flag), .flag_next(flag_next)
  );

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_CTRL: rd_mux = {{(REG_W-3){1'b0}}, ctrl_dbg, ctrl_clr, ctrl_run};
      OFS_MEN:  rd_mux = {{(REG_W-1){1'b0}}, men};
      OFS_PSC:  rd_mux = {{PPAD{1'b0}}, psc_term};
      OFS_CNT:  rd_mux = {{CPAD{1'b0}}, count};
      OFS_MAT0: rd_mux = {{CPAD{1'b0}}, mat0};
      OFS_STAT: rd_mux = {{(REG_W-1){1'b0}}, flag};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_mux : '0;
      irq       <= flag_next && men_next;
    end
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_run,
  input logic             ctrl_clr,
  input logic             ctrl_dbg,
  input logic             dbg_halt,
  input logic             men,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] mat0,
  input logic             flag,
  input logic             irq
);
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_clr |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_run && !ctrl_clr) |=> $stable(count));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl_clr |=> (count == '0));

  assert_debug_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_dbg && dbg_halt && !ctrl_clr) |=> $stable(count));

  assert_match_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (men && count == mat0) |=> flag);

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && men));
endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_run(ctrl_run), .ctrl_clr(ctrl_clr),
  .ctrl_dbg(ctrl_dbg), .dbg_halt(dbg_halt), .men(men), .count(count),
  .mat0(mat0), .flag(flag), .irq(irq)
);

// File: tb/sim_match_timer.sv
module sim_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int NVEC = 5;
  // {terminal, wait cycles M, expected count = floor((M+1)/(terminal+1))}
  localparam int VEC [NVEC][3] = '{
    '{0, 9, 10}, '{1, 9, 5}, '{2, 10, 3}, '{12, 38, 3}, '{4, 3, 0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0, dbg_halt = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  match_timer #(.ADDR_W(8), .CNT_W(CW), .PSC_W(16)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_halt(dbg_halt), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic zero_cnt();
    wr(8'h00, 32'h2);
    wr(8'h00, 32'h0);
  endtask

  task automatic run_for(input int m, input logic [31:0] ctl);
    wr(8'h00, ctl);
    repeat (m) @(negedge clk);
    wr(8'h00, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h00, rv); check("R1 ctrl", rv, 0);
    rd(8'h08, rv); check("R1 psc", rv, 0);
    rd(8'h10, rv); check("R1 mat0", rv, 0);
    rd(8'h14, rv); check("R1 stat", rv, 0);
    repeat (5) @(negedge clk);
    rd(8'h0C, rv); check("R1 count idle", rv, 0);

    // R2/R3: vector table over prescaler settings
    for (int i = 0; i < NVEC; i++) begin
      zero_cnt();
      wr(8'h08, VEC[i][0]);
      run_for(VEC[i][1], 32'h1);
      rd(8'h0C, rv); check("R2 prescaled count", rv, VEC[i][2]);
      repeat (4) @(negedge clk);
      rd(8'h0C, rv); check("R3 stopped holds", rv, VEC[i][2]);
    end

    // R11 readback and unmapped
    wr(8'h08, 32'h0);
    wr(8'h10, 32'h5A);
    rd(8'h10, rv); check("R11 mat0 readback", rv, 32'h5A);
    rd(8'h08, rv); check("R11 psc readback", rv, 0);
    rd(8'h18, rv); check("R11 unmapped", rv, 0);
    rd(8'hFC, rv); check("R11 unmapped high", rv, 0);

    // R4 clear while running
    zero_cnt();
    wr(8'h00, 32'h1);
    repeat (6) @(negedge clk);
    wr(8'h00, 32'h3);
    @(negedge clk);
    rd(8'h0C, rv); check("R4 cleared", rv, 0);
    repeat (5) @(negedge clk);
    rd(8'h0C, rv); check("R4 held at zero", rv, 0);
    wr(8'h00, 32'h0);

    // R5 debug freeze
    zero_cnt();
    dbg_halt = 1'b1;
    run_for(9, 32'h5);
    rd(8'h0C, rv); check("R5 frozen", rv, 0);
    run_for(9, 32'h1);
    rd(8'h0C, rv); check("R5 halt ignored", rv, 10);
    dbg_halt = 1'b0;

    // R10 wrap: 259 enabled cycles on an 8-bit counter
    zero_cnt();
    run_for(258, 32'h1);
    rd(8'h0C, rv); check("R10 wrap", rv, 3);
    rd(8'h14, rv); check("R10 no flag on wrap", rv, 0);

    // R6 match, counter continues
    zero_cnt();
    wr(8'h10, 32'd5);
    wr(8'h04, 32'h1);
    run_for(20, 32'h1);
    rd(8'h0C, rv); check("R6 counts past match", rv, 21);
    rd(8'h14, rv); check("R6 flag set", rv, 1);
    check("R9 irq high", {31'b0, irq}, 1);

    // R7 write zero no effect, write one clears
    wr(8'h14, 32'h0);
    rd(8'h14, rv); check("R7 zero write ignored", rv, 1);
    wr(8'h14, 32'h1);
    check("R9 irq low after clear", {31'b0, irq}, 0);
    rd(8'h14, rv); check("R7 cleared", rv, 0);

    // R8 collision: counter stopped at match value
    wr(8'h10, 32'd21);
    @(negedge clk);
    wr(8'h14, 32'h1);
    rd(8'h14, rv); check("R8 set wins", rv, 1);
    wr(8'h10, 32'd40);
    wr(8'h14, 32'h1);
    rd(8'h14, rv); check("R8 clear after move", rv, 0);

    // R9 enable gating
    wr(8'h10, 32'd21);
    @(negedge clk);
    check("R9 irq follows flag", {31'b0, irq}, 1);
    wr(8'h04, 32'h0);
    check("R9 irq dropped", {31'b0, irq}, 0);
    rd(8'h14, rv); check("R9 flag kept", rv, 1);
    wr(8'h04, 32'h1);
    check("R9 irq back", {31'b0, irq}, 1);
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h1);
    @(negedge clk);
    rd(8'h14, rv); check("R6 no set when disabled", rv, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule